// File: doc/BRIEF.md
# Transmit Abort Detection Unit

This unit supervises a single requested packet transmission from the moment the host raises the request until the request drops again. While the request is pending it watches the medium-busy line during deferral, classifies every collision reported by the serialiser against the number of bytes already sent, and checks the frame length against the configured maximum. At each cycle it decides whether the packet is still in flight, has completed, has been cancelled by the host, or must be aborted.

Five causes can end a transmission in an abort: too many collisions, a collision outside the collision window, a collision after 64 bytes, a medium that stays busy past the deferral limit of 2.4287 ms, and a frame longer than the limit. Each cause has its own rule that can suppress it. When a transmission ends for any reason, the request bit drops and a one-cycle write strobe is issued together with the address of the status record, which is one past the transmit end pointer. An aborted packet is never restarted by the unit. The abort and late-collision status bits stay set until the host clears them. In full-duplex operation, only the frame length can cause an abort.

The deferral limit is counted in clock cycles. The count is derived from the `CLK_HZ` parameter as floor(CLK_HZ × 24287 / 10^7). Backoff timing, serialisation and the memory write itself belong to neighbouring blocks.

Top module: `tx_abort_unit`

## Requirements
- R1: In the first cycle after a start, a frame with `frame_len > cfg_max_len` aborts. This does not happen when `cfg_huge_en` or `pkt_huge_ovr` is 1. The check also applies in full-duplex operation.
- R2: A collision with `byte_cnt <= cfg_col_window` returns the unit to deferral with the request still set. This holds while the number of collisions in this request does not exceed `cfg_retry_max`. The collision that makes the count exceed it aborts, so `cfg_retry_max = 0` aborts on the first collision.
- R3: A collision with `cfg_col_window < byte_cnt < 64` aborts and leaves `late_col_sts` unchanged.
- R4: A collision with `byte_cnt >= 64` aborts and sets `late_col_sts`.
- R5: While deferring in half duplex, `DEFER_LIM` consecutive busy cycles abort the packet, with the abort visible `DEFER_LIM` cycles after the start edge. When `cfg_defer_en` is 1 the unit waits instead. A new deferral after a collision starts a new count.
- R6: When `full_duplex` is 1, `medium_busy` and `col_event` have no effect. The unit goes from deferral to sending at once.
- R7: A transmission ends by completion, abort or cancel. On the same edge `tx_req` drops, `stat_wr` pulses for one cycle and `stat_addr` takes `tx_end_ptr + 1` modulo 2^`ADDR_W`.
- R8: An abort sets `abort_sts`. `abort_sts` is cleared only by `sts_clr_abort` and `late_col_sts` only by `sts_clr_late`. A set on the same edge wins over a clear.
- R9: After a transmission ends, `tx_req` stays 0 until the next `tx_start`. `tx_start` while a request is pending is ignored.
- R10: `tx_done` while sending gives a one-cycle `tx_ok` pulse. A `host_cancel` ends the request with no abort, no late-collision status and no `tx_ok`. It has priority over every other event in the same cycle.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Host requests a transmission |
| host_cancel | input | 1 | Host withdraws the pending request |
| full_duplex | input | 1 | Link is full duplex |
| medium_busy | input | 1 | Carrier seen on the medium |
| col_event | input | 1 | Collision reported this cycle |
| byte_cnt | input | BCNT_W | Bytes sent so far in the current attempt |
| tx_done | input | 1 | Serialiser finished the frame |
| frame_len | input | LEN_W | Length of the pending frame |
| tx_end_ptr | input | ADDR_W | Address of the last frame byte |
| cfg_retry_max | input | RETRY_W | Largest number of collisions that are retried |
| cfg_col_window | input | WIN_W | Collision window in bytes |
| cfg_max_len | input | LEN_W | Largest allowed frame length |
| cfg_defer_en | input | 1 | Wait indefinitely for the medium |
| cfg_huge_en | input | 1 | Allow frames of any length |
| pkt_huge_ovr | input | 1 | Per-packet allowance for an oversize frame |
| sts_clr_abort | input | 1 | Host clear of the abort status |
| sts_clr_late | input | 1 | Host clear of the late-collision status |
| tx_req | output | 1 | Transmission request pending |
| abort_sts | output | 1 | Sticky abort status |
| late_col_sts | output | 1 | Sticky late-collision status |
| stat_wr | output | 1 | Status record write strobe |
| stat_addr | output | ADDR_W | Status record address |
| tx_ok | output | 1 | Successful completion pulse |

## Verification
The assertions check on every cycle that:
- the request is low whenever a status record is written;
- the write strobe lasts a single cycle;
- the record address follows the end pointer;
- both status bits hold until cleared;
- the request never restarts without a start;
- the late-collision bit never rises after a full-duplex cycle;
- a completion pulse always comes with a record write.

Only the bench's scenarios can show which cause ends a particular packet, and when. These include:
- the byte-count thresholds around the window and the 64-byte mark;
- the exact collision count at which retries run out;
- the deferral limit measured in cycles;
- the grid of length, huge-enable and override settings.

// File: rtl/tx_abort_pkg.sv
package tx_abort_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DEFER = 2'd1,
    ST_SEND  = 2'd2
  } tx_state_e;

  localparam int unsigned LATE_BYTES = 64;

endpackage

// File: rtl/tx_abort_rst_sync.sv
module tx_abort_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];

endmodule

// File: rtl/tx_abort_len_check.sv
module tx_abort_len_check #(
  parameter int unsigned LEN_W = 11
) (
  input  logic [LEN_W-1:0] frame_len,
  input  logic [LEN_W-1:0] cfg_max_len,
  input  logic             cfg_huge_en,
  input  logic             pkt_huge_ovr,
  output logic             oversize
);

  logic too_long;

  always_comb begin
    too_long = frame_len > cfg_max_len;
    oversize = too_long && !cfg_huge_en && !pkt_huge_ovr;
  end

endmodule

// File: rtl/tx_abort_defer_timer.sv
module tx_abort_defer_timer #(
  parameter int unsigned LIMIT = 60717,
  localparam int unsigned CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  output logic expired
);

  localparam logic [CNT_W-1:0] TERM = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    expired = count_en && (cnt_q == TERM);
    if (!count_en)          cnt_d = '0;
    else if (cnt_q == TERM) cnt_d = cnt_q;
    else                    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tx_abort_col_judge.sv
module tx_abort_col_judge
  import tx_abort_pkg::*;
#(
  parameter int unsigned BCNT_W  = 11,
  parameter int unsigned WIN_W   = 6,
  parameter int unsigned RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               col_valid,
  input  logic [BCNT_W-1:0]  byte_cnt,
  input  logic [WIN_W-1:0]   cfg_col_window,
  input  logic [RETRY_W-1:0] cfg_retry_max,
  output logic               late_beyond,
  output logic               late_window,
  output logic               retry_exhausted,
  output logic               retry_again
);

  logic [RETRY_W-1:0] col_cnt_q, col_cnt_d;
  logic [RETRY_W:0]   col_cnt_inc;
  logic               early;

  always_comb begin
    late_beyond     = col_valid && (byte_cnt >= BCNT_W'(LATE_BYTES));
    late_window     = col_valid && !late_beyond &&
                      (byte_cnt > BCNT_W'(cfg_col_window));
    early           = col_valid && !late_beyond && !late_window;
    col_cnt_inc     = {1'b0, col_cnt_q} + (RETRY_W+1)'(1);
    retry_exhausted = early && (col_cnt_inc > {1'b0, cfg_retry_max});
    retry_again     = early && !retry_exhausted;

    if (clr)              col_cnt_d = '0;
    else if (retry_again) col_cnt_d = col_cnt_inc[RETRY_W-1:0];
    else                  col_cnt_d = col_cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_cnt_q <= '0;
    else        col_cnt_q <= col_cnt_d;
  end

endmodule

// File: rtl/tx_abort_unit.sv
module tx_abort_unit
  import tx_abort_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 25_000_000,
  parameter int unsigned BCNT_W  = 11,
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned RETRY_W = 4,
  parameter int unsigned WIN_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_start,
  input  logic               host_cancel,
  input  logic               full_duplex,
  input  logic               medium_busy,
  input  logic               col_event,
  input  logic [BCNT_W-1:0]  byte_cnt,
  input  logic               tx_done,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic [ADDR_W-1:0]  tx_end_ptr,
  input  logic [RETRY_W-1:0] cfg_retry_max,
  input  logic [WIN_W-1:0]   cfg_col_window,
  input  logic [LEN_W-1:0]   cfg_max_len,
  input  logic               cfg_defer_en,
  input  logic               cfg_huge_en,
  input  logic               pkt_huge_ovr,
  input  logic               sts_clr_abort,
  input  logic               sts_clr_late,
  output logic               tx_req,
  output logic               abort_sts,
  output logic               late_col_sts,
  output logic               stat_wr,
  output logic [ADDR_W-1:0]  stat_addr,
  output logic               tx_ok
);

  localparam longint unsigned DEFER_LIM_L =
    (64'(CLK_HZ) * 64'd24287) / 64'd10000000;
  localparam int unsigned DEFER_LIM =
    (DEFER_LIM_L < 64'd2) ? 2 : int'(DEFER_LIM_L);

  logic rst_core_n;

  tx_abort_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  tx_state_e state_q, state_d;
  logic      in_defer, in_send, active;

  assign in_defer = (state_q == ST_DEFER);
  assign in_send  = (state_q == ST_SEND);
  assign active   = (state_q != ST_IDLE);

  logic oversize;

  tx_abort_len_check #(.LEN_W(LEN_W)) u_len (
    .frame_len    (frame_len),
    .cfg_max_len  (cfg_max_len),
    .cfg_huge_en  (cfg_huge_en),
    .pkt_huge_ovr (pkt_huge_ovr),
    .oversize     (oversize)
  );

  logic defer_count_en, defer_expired;

  assign defer_count_en = in_defer && !full_duplex && medium_busy;

  tx_abort_defer_timer #(.LIMIT(DEFER_LIM)) u_defer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .count_en (defer_count_en),
    .expired  (defer_expired)
  );

  logic col_valid, start_ok;
  logic late_beyond, late_window, retry_exhausted, retry_again;

  assign col_valid = in_send && !full_duplex && col_event;
  assign start_ok  = (state_q == ST_IDLE) && tx_start;

  tx_abort_col_judge #(
    .BCNT_W  (BCNT_W),
    .WIN_W   (WIN_W),
    .RETRY_W (RETRY_W)
  ) u_col (
    .clk             (clk),
    .rst_n           (rst_core_n),
    .clr             (start_ok),
    .col_valid       (col_valid),
    .byte_cnt        (byte_cnt),
    .cfg_col_window  (cfg_col_window),
    .cfg_retry_max   (cfg_retry_max),
    .late_beyond     (late_beyond),
    .late_window     (late_window),
    .retry_exhausted (retry_exhausted),
    .retry_again     (retry_again)
  );

  logic cancel_now, abort_now, ok_now, end_now, late_set;
  logic req_d, abort_d, late_d;
  logic addr_en;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    cancel_now = active && host_cancel;
    abort_now  = !cancel_now &&
                 ((in_defer && oversize) ||
                  (defer_count_en && defer_expired && !cfg_defer_en) ||
                  late_beyond || late_window || retry_exhausted);
    ok_now     = !cancel_now && !abort_now && in_send && tx_done && !retry_again;
    end_now    = cancel_now || abort_now || ok_now;
    late_set   = !cancel_now && late_beyond;

    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (tx_start) state_d = ST_DEFER;
      ST_DEFER: begin
        if (end_now)                         state_d = ST_IDLE;
        else if (full_duplex || !medium_busy) state_d = ST_SEND;
      end
      ST_SEND: begin
        if (end_now)          state_d = ST_IDLE;
        else if (retry_again) state_d = ST_DEFER;
      end
      default: state_d = ST_IDLE;
    endcase

    if (end_now)       req_d = 1'b0;
    else if (start_ok) req_d = 1'b1;
    else               req_d = tx_req;

    if (abort_now)          abort_d = 1'b1;
    else if (sts_clr_abort) abort_d = 1'b0;
    else                    abort_d = abort_sts;

    if (late_set)          late_d = 1'b1;
    else if (sts_clr_late) late_d = 1'b0;
    else                   late_d = late_col_sts;

    addr_en = end_now;
    addr_d  = tx_end_ptr + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q      <= ST_IDLE;
      tx_req       <= 1'b0;
      abort_sts    <= 1'b0;
      late_col_sts <= 1'b0;
      stat_wr      <= 1'b0;
      tx_ok        <= 1'b0;
    end else begin
      state_q      <= state_d;
      tx_req       <= req_d;
      abort_sts    <= abort_d;
      late_col_sts <= late_d;
      stat_wr      <= end_now;
      tx_ok        <= ok_now;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  stat_addr <= '0;
    else if (addr_en) stat_addr <= addr_d;
  end

endmodule

// File: rtl/tx_abort_unit_chk.sv
module tx_abort_unit_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_start,
  input logic              full_duplex,
  input logic [ADDR_W-1:0] tx_end_ptr,
  input logic              sts_clr_abort,
  input logic              sts_clr_late,
  input logic              tx_req,
  input logic              abort_sts,
  input logic              late_col_sts,
  input logic              stat_wr,
  input logic [ADDR_W-1:0] stat_addr,
  input logic              tx_ok
);

  AST_REQ_LOW_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |-> !tx_req); // R7

  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> !stat_wr); // R7

  AST_RECORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |-> (stat_addr == ADDR_W'($past(tx_end_ptr) + ADDR_W'(1)))); // R7

  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_sts && !sts_clr_abort) |=> abort_sts); // R8

  AST_LATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (late_col_sts && !sts_clr_late) |=> late_col_sts); // R8

  AST_NO_AUTO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_req && !tx_start) |=> !tx_req); // R9

  AST_FDX_NO_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_col_sts) |-> !$past(full_duplex)); // R6

  AST_OK_WITH_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok |-> (stat_wr && !$rose(abort_sts))); // R10

endmodule

bind tx_abort_unit tx_abort_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_start      (tx_start),
  .full_duplex   (full_duplex),
  .tx_end_ptr    (tx_end_ptr),
  .sts_clr_abort (sts_clr_abort),
  .sts_clr_late  (sts_clr_late),
  .tx_req        (tx_req),
  .abort_sts     (abort_sts),
  .late_col_sts  (late_col_sts),
  .stat_wr       (stat_wr),
  .stat_addr     (stat_addr),
  .tx_ok         (tx_ok)
);

// File: tb/tx_abort_unit_tb_top.sv
module tx_abort_unit_tb_top;

  localparam int unsigned CLK_HZ  = 1_000_000;
  localparam int unsigned BCNT_W  = 11;
  localparam int unsigned LEN_W   = 11;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned RETRY_W = 4;
  localparam int unsigned WIN_W   = 6;
  localparam int          LIM     = (CLK_HZ / 1000) * 24287 / 10000;
  localparam int          MAXLEN  = 100;
  localparam int          WIN     = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_start, host_cancel, full_duplex, medium_busy, col_event, tx_done;
  logic [BCNT_W-1:0]  byte_cnt;
  logic [LEN_W-1:0]   frame_len, cfg_max_len;
  logic [ADDR_W-1:0]  tx_end_ptr, stat_addr;
  logic [RETRY_W-1:0] cfg_retry_max;
  logic [WIN_W-1:0]   cfg_col_window;
  logic cfg_defer_en, cfg_huge_en, pkt_huge_ovr, sts_clr_abort, sts_clr_late;
  logic tx_req, abort_sts, late_col_sts, stat_wr, tx_ok;

  always #10 clk = ~clk;

  tx_abort_unit #(
    .CLK_HZ (CLK_HZ), .BCNT_W (BCNT_W), .LEN_W (LEN_W),
    .ADDR_W (ADDR_W), .RETRY_W (RETRY_W), .WIN_W (WIN_W)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .tx_start (tx_start), .host_cancel (host_cancel),
    .full_duplex (full_duplex), .medium_busy (medium_busy), .col_event (col_event),
    .byte_cnt (byte_cnt), .tx_done (tx_done), .frame_len (frame_len),
    .tx_end_ptr (tx_end_ptr), .cfg_retry_max (cfg_retry_max),
    .cfg_col_window (cfg_col_window), .cfg_max_len (cfg_max_len),
    .cfg_defer_en (cfg_defer_en), .cfg_huge_en (cfg_huge_en),
    .pkt_huge_ovr (pkt_huge_ovr), .sts_clr_abort (sts_clr_abort),
    .sts_clr_late (sts_clr_late), .tx_req (tx_req), .abort_sts (abort_sts),
    .late_col_sts (late_col_sts), .stat_wr (stat_wr), .stat_addr (stat_addr),
    .tx_ok (tx_ok)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_tx();
    @(negedge clk); tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
  endtask

  task automatic collide(input int b);
    col_event = 1'b1; byte_cnt = BCNT_W'(b);
    @(negedge clk);
    col_event = 1'b0;
  endtask

  task automatic cancel_tx();
    host_cancel = 1'b1;
    @(negedge clk);
    host_cancel = 1'b0;
  endtask

  task automatic clr_sts();
    sts_clr_abort = 1'b1; sts_clr_late = 1'b1;
    @(negedge clk);
    sts_clr_abort = 1'b0; sts_clr_late = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int blist[10] = '{0, 8, 19, 20, 21, 40, 63, 64, 65, 72};
    int plist[4]  = '{0, 5, 254, 255};
    int n;
    rst_n = 1'b0; tx_start = 0; host_cancel = 0; full_duplex = 0; medium_busy = 0;
    col_event = 0; tx_done = 0; byte_cnt = '0; frame_len = LEN_W'(60);
    tx_end_ptr = 8'h10; cfg_retry_max = 4'd15; cfg_col_window = WIN_W'(WIN);
    cfg_max_len = LEN_W'(MAXLEN); cfg_defer_en = 0; cfg_huge_en = 0; pkt_huge_ovr = 0;
    sts_clr_abort = 0; sts_clr_late = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 tx_req", tx_req, 0);
    chk("R11 abort_sts", abort_sts, 0);
    chk("R11 late_col_sts", late_col_sts, 0);
    chk("R11 stat_wr", stat_wr, 0);
    chk("R11 stat_addr", stat_addr, 0);
    chk("R11 tx_ok", tx_ok, 0);

    // R1 oversize grid, both duplex modes
    for (int fd = 0; fd < 2; fd++)
      for (int hg = 0; hg < 2; hg++)
        for (int ov = 0; ov < 2; ov++)
          for (int len = MAXLEN - 2; len <= MAXLEN + 2; len++) begin
            bit exp_ab;
            full_duplex = fd[0]; cfg_huge_en = hg[0]; pkt_huge_ovr = ov[0];
            frame_len = LEN_W'(len);
            exp_ab = (len > MAXLEN) && (hg == 0) && (ov == 0);
            start_tx();
            @(negedge clk);
            chk("R1 abort", abort_sts, 32'(exp_ab));
            chk("R1 request", tx_req, 32'(!exp_ab));
            if (!exp_ab) cancel_tx();
            clr_sts();
          end
    full_duplex = 0; cfg_huge_en = 0; pkt_huge_ovr = 0; frame_len = LEN_W'(60);

    // R3 / R4 / R2 collision byte-count sweep
    for (int i = 0; i < 10; i++) begin
      int b;
      b = blist[i];
      start_tx();
      @(negedge clk);
      collide(b);
      chk("R4 late status", late_col_sts, 32'(b >= 64));
      chk("R3 abort", abort_sts, 32'((b >= 64) || (b > WIN)));
      chk("R2 request kept", tx_req, 32'(!((b >= 64) || (b > WIN))));
      if (tx_req) cancel_tx();
      clr_sts();
    end

    // R2 retry exhaustion, exact collision count
    for (int r = 0; r < 4; r++) begin
      cfg_retry_max = RETRY_W'(r);
      start_tx();
      @(negedge clk);
      for (int k = 1; k <= r + 1; k++) begin
        collide(0);
        chk("R2 retry abort", abort_sts, 32'(k > r));
        chk("R2 retry request", tx_req, 32'(k <= r));
        if (k <= r) @(negedge clk);
      end
      clr_sts();
    end
    cfg_retry_max = 4'd15;

    // R5 deferral limit in cycles
    medium_busy = 1'b1;
    start_tx();
    n = 0;
    while (!abort_sts && n < LIM + 10) begin @(negedge clk); n++; end
    chk("R5 defer cycles", n, LIM);
    chk("R7 request low after defer abort", tx_req, 0);
    // R9 no restart after abort
    repeat (5) @(negedge clk);
    chk("R9 request stays low", tx_req, 0);
    // R8 sticky, separate clears
    sts_clr_late = 1'b1; @(negedge clk); sts_clr_late = 1'b0;
    chk("R8 abort kept", abort_sts, 1);
    sts_clr_abort = 1'b1; @(negedge clk); sts_clr_abort = 1'b0;
    chk("R8 abort cleared", abort_sts, 0);

    // R5 defer enable waits; then R10 success
    cfg_defer_en = 1'b1;
    start_tx();
    repeat (LIM + 10) @(negedge clk);
    chk("R5 defer_en request", tx_req, 1);
    chk("R5 defer_en abort", abort_sts, 0);
    medium_busy = 1'b0;
    @(negedge clk);
    tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    chk("R10 tx_ok", tx_ok, 1);
    chk("R10 stat_wr", stat_wr, 1);
    chk("R10 no abort", abort_sts, 0);
    @(negedge clk);
    chk("R10 tx_ok pulse", tx_ok, 0);
    cfg_defer_en = 1'b0;

    // R5 new count after a retry
    start_tx();
    @(negedge clk);
    collide(0);
    medium_busy = 1'b1;
    n = 0;
    while (!abort_sts && n < LIM + 10) begin @(negedge clk); n++; end
    chk("R5 defer after retry", n, LIM);
    medium_busy = 1'b0;
    clr_sts();

    // R6 full duplex ignores busy and collisions
    full_duplex = 1'b1; medium_busy = 1'b1;
    start_tx();
    @(negedge clk);
    collide(100);
    chk("R6 no abort", abort_sts, 0);
    chk("R6 no late", late_col_sts, 0);
    repeat (LIM + 5) @(negedge clk);
    chk("R6 request held", tx_req, 1);
    tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    chk("R6 completes", tx_ok, 1);
    full_duplex = 1'b0; medium_busy = 1'b0;

    // R7 record address with wrap
    for (int i = 0; i < 4; i++) begin
      tx_end_ptr = ADDR_W'(plist[i]);
      start_tx();
      cancel_tx();
      chk("R7 stat_wr", stat_wr, 1);
      chk("R7 stat_addr", stat_addr, (plist[i] + 1) % 256);
      chk("R7 request low", tx_req, 0);
      @(negedge clk);
      chk("R7 stat_wr pulse", stat_wr, 0);
    end

    // R10 cancel priority over done and late collision
    start_tx();
    @(negedge clk);
    host_cancel = 1'b1; tx_done = 1'b1; col_event = 1'b1; byte_cnt = BCNT_W'(100);
    @(negedge clk);
    host_cancel = 1'b0; tx_done = 1'b0; col_event = 1'b0;
    chk("R10 cancel request", tx_req, 0);
    chk("R10 cancel abort", abort_sts, 0);
    chk("R10 cancel late", late_col_sts, 0);
    chk("R10 cancel tx_ok", tx_ok, 0);

    // R9 start ignored while pending
    cfg_retry_max = 4'd0;
    start_tx();
    tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
    collide(0);
    chk("R9 retry count kept", abort_sts, 1);
    clr_sts();

    finish_run();
  end

endmodule